// File: doc/BRIEF.md
# Serial Command Front End with Channel Register File

This block sits behind a chip-select framed serial link and turns received bits into register operations for a four-channel analog device. The link delivers one data bit per cycle in which a bit strobe is high; the bit timing itself is handled elsewhere. Each frame opens with an identification byte. This byte is compared with a fixed device-type code and with the two strapped address pins. If it matches, the next byte is decoded into an operation code, a data-register index and a channel index.

Every channel owns one volatile control register and four data registers. Channels 0 and 1 drive potentiometers, and their control register carries a six-bit wiper position. Channels 2 and 3 drive comparators, and their control register carries a power bit, an output-enable bit and an output-latch bit. Writes and copies take effect only when chip select returns high at the close of a complete frame. A read shifts one byte out, most significant bit first. All register contents are presented on output ports, together with the per-channel decoded fields.

Top module: `cmdfe_top`

## Requirements
- R1: After reset every control register and every data register reads 0, and `sdo` is 0.
- R2: A frame starts only when chip select has been seen high and then goes low. Bits received while chip select is low and has not been high since reset change nothing.
- R3: The first byte of a frame is accepted only if bits 7:4 equal 0101, bits 3:2 equal 00 and bits 1:0 equal `addrPins`. Otherwise the rest of the frame has no effect.
- R4: In the second byte, bits 7:4 carry the operation code, bits 3:2 the data-register index and bits 1:0 the channel index. Channels 0 and 1 are potentiometer channels and channels 2 and 3 are comparator channels.
- R5: Operation 1010 takes a third byte and writes it to the selected control register when chip select rises. Bits 7:6 of a control register always read 0.
- R6: Operation 1100 takes a third byte and writes all 8 bits of it to the selected data register when chip select rises.
- R7: Operation 1001 reads the control register and operation 1011 reads the selected data register. The value appears on `sdo` MSB first: its MSB is visible in the cycle after the last instruction bit, and the output advances one bit per bit strobe for 8 bits. At all other times `sdo` is 0.
- R8: When chip select rises directly after the instruction byte, operation 1101 copies the selected data register into the control register, with bits 7:6 cleared. Operation 1110 copies the control register into the selected data register.
- R9: Any other operation code leaves every register unchanged.
- R10: A commit requires chip select to rise exactly on a byte boundary after the final byte. A partial byte, or any further bit, cancels the frame. Chip select high always returns the decoder to waiting for an identification byte.
- R11: `wiperPos` holds bits 5:0 of the control registers of channels 0 and 1. `cmpPower`, `cmpOutEn` and `cmpLatch` hold bits 0, 1 and 2 of the control registers of channels 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select framing a command |
| bitStb | input | 1 | One received bit is valid on `sdi` this cycle |
| sdi | input | 1 | Serial data in, MSB first |
| addrPins | input | 2 | Strapped device address |
| sdo | output | 1 | Serial read data, MSB first |
| ctrlRegs | output | 32 | Control registers, channel c at bits 8c+7:8c |
| dataRegs | output | 128 | Data registers, channel c register r at bits 8(4c+r)+7 down to 8(4c+r) |
| wiperPos | output | 12 | Wiper positions of channels 0 and 1 |
| cmpPower | output | 2 | Comparator power bits of channels 2 and 3 |
| cmpOutEn | output | 2 | Comparator output-enable bits |
| cmpLatch | output | 2 | Comparator output-latch bits |

## Verification
Four properties are checked on every cycle. No register changes unless chip select was high in the previous cycle. Bits 7:6 of every control register stay clear. `sdo` is quiet after chip select is high. `sdo` holds its value in any low-select cycle without a bit strobe. The remaining behaviour can only be shown by the bench's frames. This covers the acceptance or rejection of identification bytes, the routing of the channel and register fields, read-back order, the copy directions, and the cancellation of frames that end mid-byte or run one bit long. A behavioural model fed by the same bit stream checks these on every clock.

// File: rtl/cmdfe_pkg.sv
package cmdfe_pkg;
  localparam int BYTE_W  = 8;
  localparam int CH_W    = 2;
  localparam int RG_W    = 2;
  localparam int NUM_CH  = 1 << CH_W;
  localparam int NUM_REG = 1 << RG_W;
  localparam int NUM_POT = 2;
  localparam int NUM_CMP = NUM_CH - NUM_POT;
  localparam int WIPER_W = 6;
  localparam int CNT_W   = $clog2(BYTE_W);
  localparam logic [BYTE_W-1:0] CTRL_MASK = BYTE_W'((1 << WIPER_W) - 1);

  localparam logic [3:0] OP_RD_CTRL = 4'b1001;
  localparam logic [3:0] OP_WR_CTRL = 4'b1010;
  localparam logic [3:0] OP_RD_DATA = 4'b1011;
  localparam logic [3:0] OP_WR_DATA = 4'b1100;
  localparam logic [3:0] OP_D2C     = 4'b1101;
  localparam logic [3:0] OP_C2D     = 4'b1110;

  typedef enum logic [2:0] {
    ST_HOLD, ST_ID, ST_INSTR, ST_WDATA, ST_READ, ST_COMMIT
  } fstate_e;

  typedef struct packed {
    logic              ldCtrl;
    logic              ldData;
    logic              shOut;
    logic              sdoEn;
    logic              wrCtrl;
    logic              wrData;
    logic              d2c;
    logic              c2d;
    logic [CH_W-1:0]   ch;
    logic [RG_W-1:0]   rg;
    logic [BYTE_W-1:0] wdata;
  } strobe_t;

  function automatic logic [NUM_CH*BYTE_W-1:0] ctrlUnusedMask();
    logic [NUM_CH*BYTE_W-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CH; c++) m[c*BYTE_W +: BYTE_W] = ~CTRL_MASK;
    return m;
  endfunction
endpackage

// File: rtl/cmdfe_ctrl.sv
module cmdfe_ctrl
  import cmdfe_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b0101
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csN,
  input  logic            bitStb,
  input  logic            sdi,
  input  logic [1:0]      addrPins,
  output strobe_t         stb
);
  fstate_e             state;
  logic [CNT_W-1:0]    bitCnt;
  logic [BYTE_W-2:0]   shReg;
  logic [3:0]          opR;
  logic [CH_W-1:0]     chR;
  logic [RG_W-1:0]     rgR;
  logic [BYTE_W-1:0]   wdR;

  logic [BYTE_W-1:0]   byteVal;
  logic                byteDone;
  logic                idOk;
  logic                instrDone;
  logic                commit;

  assign byteVal   = {shReg, sdi};
  assign byteDone  = !csN && bitStb && (bitCnt == CNT_W'(BYTE_W-1));
  assign idOk      = (byteVal[7:4] == DEV_TYPE) && (byteVal[3:2] == 2'b00) &&
                     (byteVal[1:0] == addrPins);
  assign instrDone = byteDone && (state == ST_INSTR);
  assign commit    = csN && (state == ST_COMMIT);

  always_comb begin
    stb.ch     = instrDone ? byteVal[CH_W-1:0] : chR;
    stb.rg     = instrDone ? byteVal[CH_W +: RG_W] : rgR;
    stb.ldCtrl = instrDone && (byteVal[7:4] == OP_RD_CTRL);
    stb.ldData = instrDone && (byteVal[7:4] == OP_RD_DATA);
    stb.shOut  = !csN && bitStb && (state == ST_READ);
    stb.sdoEn  = (state == ST_READ);
    stb.wrCtrl = commit && (opR == OP_WR_CTRL);
    stb.wrData = commit && (opR == OP_WR_DATA);
    stb.d2c    = commit && (opR == OP_D2C);
    stb.c2d    = commit && (opR == OP_C2D);
    stb.wdata  = wdR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_HOLD;
      bitCnt <= '0;
      shReg  <= '0;
      opR    <= '0;
      chR    <= '0;
      rgR    <= '0;
      wdR    <= '0;
    end else if (csN) begin
      state  <= ST_ID;
      bitCnt <= '0;
    end else if (bitStb) begin
      bitCnt <= bitCnt + 1'b1;
      shReg  <= byteVal[BYTE_W-2:0];
      unique case (state)
        ST_ID: if (byteDone) state <= idOk ? ST_INSTR : ST_HOLD;
        ST_INSTR: if (byteDone) begin
          opR <= byteVal[7:4];
          chR <= byteVal[CH_W-1:0];
          rgR <= byteVal[CH_W +: RG_W];
          case (byteVal[7:4])
            OP_RD_CTRL, OP_RD_DATA: state <= ST_READ;
            OP_WR_CTRL, OP_WR_DATA: state <= ST_WDATA;
            OP_D2C, OP_C2D:         state <= ST_COMMIT;
            default:                state <= ST_HOLD;
          endcase
        end
        ST_WDATA: if (byteDone) begin
          wdR   <= byteVal;
          state <= ST_COMMIT;
        end
        ST_READ:   if (byteDone) state <= ST_HOLD;
        ST_COMMIT: state <= ST_HOLD;
        default:   state <= ST_HOLD;
      endcase
    end
  end
endmodule

// File: rtl/cmdfe_dpath.sv
module cmdfe_dpath
  import cmdfe_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  strobe_t                           stb,
  output logic                              sdo,
  output logic [NUM_CH*BYTE_W-1:0]          ctrlRegs,
  output logic [NUM_CH*NUM_REG*BYTE_W-1:0]  dataRegs,
  output logic [NUM_POT*WIPER_W-1:0]        wiperPos,
  output logic [NUM_CMP-1:0]                cmpPower,
  output logic [NUM_CMP-1:0]                cmpOutEn,
  output logic [NUM_CMP-1:0]                cmpLatch
);
  logic [BYTE_W-1:0] ctrlQ [NUM_CH];
  logic [BYTE_W-1:0] dataQ [NUM_CH][NUM_REG];
  logic [BYTE_W-1:0] outReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) begin
        ctrlQ[c] <= '0;
        for (int r = 0; r < NUM_REG; r++) dataQ[c][r] <= '0;
      end
      outReg <= '0;
    end else begin
      if (stb.wrCtrl) ctrlQ[stb.ch] <= stb.wdata & CTRL_MASK;
      if (stb.d2c)    ctrlQ[stb.ch] <= dataQ[stb.ch][stb.rg] & CTRL_MASK;
      if (stb.wrData) dataQ[stb.ch][stb.rg] <= stb.wdata;
      if (stb.c2d)    dataQ[stb.ch][stb.rg] <= ctrlQ[stb.ch];
      if (stb.ldCtrl)      outReg <= ctrlQ[stb.ch];
      else if (stb.ldData) outReg <= dataQ[stb.ch][stb.rg];
      else if (stb.shOut)  outReg <= {outReg[BYTE_W-2:0], 1'b0};
    end
  end

  assign sdo = stb.sdoEn & outReg[BYTE_W-1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ctrlRegs[c*BYTE_W +: BYTE_W] = ctrlQ[c];
    for (genvar r = 0; r < NUM_REG; r++) begin : g_rg
      assign dataRegs[(c*NUM_REG+r)*BYTE_W +: BYTE_W] = dataQ[c][r];
    end
    if (c < NUM_POT) begin : g_pot
      assign wiperPos[c*WIPER_W +: WIPER_W] = ctrlQ[c][WIPER_W-1:0];
    end else begin : g_cmp
      assign cmpPower[c-NUM_POT] = ctrlQ[c][0];
      assign cmpOutEn[c-NUM_POT] = ctrlQ[c][1];
      assign cmpLatch[c-NUM_POT] = ctrlQ[c][2];
    end
  end
endmodule

// File: rtl/cmdfe_top.sv
module cmdfe_top
  import cmdfe_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b0101
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              csN,
  input  logic                              bitStb,
  input  logic                              sdi,
  input  logic [1:0]                        addrPins,
  output logic                              sdo,
  output logic [NUM_CH*BYTE_W-1:0]          ctrlRegs,
  output logic [NUM_CH*NUM_REG*BYTE_W-1:0]  dataRegs,
  output logic [NUM_POT*WIPER_W-1:0]        wiperPos,
  output logic [NUM_CMP-1:0]                cmpPower,
  output logic [NUM_CMP-1:0]                cmpOutEn,
  output logic [NUM_CMP-1:0]                cmpLatch
);
  strobe_t stb;

  cmdfe_ctrl #(.DEV_TYPE(DEV_TYPE)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .bitStb(bitStb), .sdi(sdi),
    .addrPins(addrPins), .stb(stb)
  );

  cmdfe_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .sdo(sdo),
    .ctrlRegs(ctrlRegs), .dataRegs(dataRegs), .wiperPos(wiperPos),
    .cmpPower(cmpPower), .cmpOutEn(cmpOutEn), .cmpLatch(cmpLatch)
  );
endmodule

// File: rtl/cmdfe_chk.sv
module cmdfe_chk
  import cmdfe_pkg::*;
(
  input logic                              clk,
  input logic                              rstN,
  input logic                              csN,
  input logic                              bitStb,
  input logic                              sdo,
  input logic [NUM_CH*BYTE_W-1:0]          ctrlRegs,
  input logic [NUM_CH*NUM_REG*BYTE_W-1:0]  dataRegs
);
  localparam logic [NUM_CH*BYTE_W-1:0] HI_BITS = ctrlUnusedMask();

  // R10
  commit_only_on_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csN |=> ($stable(ctrlRegs) && $stable(dataRegs)));

  // R5
  ctrl_top_bits_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRegs & HI_BITS) == '0);

  // R7
  sdo_quiet_after_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !sdo);

  // R7
  sdo_holds_without_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !bitStb) |=> $stable(sdo));
endmodule

bind cmdfe_top cmdfe_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .bitStb(bitStb), .sdo(sdo),
  .ctrlRegs(ctrlRegs), .dataRegs(dataRegs)
);

// File: tb/tb_cmdfe_top.sv
module tb_cmdfe_top;
  logic clk = 0, rstN = 0, csN = 0, bitStb = 0, sdi = 0;
  logic [1:0] addrPins = 2'b10;
  logic sdo;
  logic [31:0] ctrlRegs;
  logic [127:0] dataRegs;
  logic [11:0] wiperPos;
  logic [1:0] cmpPower, cmpOutEn, cmpLatch;

  cmdfe_top dut (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  string curReq = "R1";
  logic lastSdo;

  // behavioural reference
  logic [7:0] mCtrl [4];
  logic [7:0] mData [4][4];
  bit q[$];
  bit armed;

  function automatic logic [7:0] qByte(int idx);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[7-i] = q[idx*8+i];
    return v;
  endfunction

  function automatic bit idGood();
    return qByte(0) == {4'b0101, 2'b00, addrPins};
  endfunction

  task automatic applyFrame();
    logic [7:0] b1, b2;
    int ch, rg;
    if (q.size() != 16 && q.size() != 24) return;
    if (!idGood()) return;
    b1 = qByte(1); ch = b1[1:0]; rg = b1[3:2];
    if (q.size() == 24) begin
      b2 = qByte(2);
      if (b1[7:4] == 4'hA) mCtrl[ch] = b2 & 8'h3F;
      if (b1[7:4] == 4'hC) mData[ch][rg] = b2;
    end else begin
      if (b1[7:4] == 4'hD) mCtrl[ch] = mData[ch][rg] & 8'h3F;
      if (b1[7:4] == 4'hE) mData[ch][rg] = mCtrl[ch];
    end
  endtask

  function automatic logic expSdo();
    int n;
    logic [7:0] b1, v;
    n = q.size();
    if (n < 16 || n > 23) return 1'b0;
    if (!idGood()) return 1'b0;
    b1 = qByte(1);
    if (b1[7:4] == 4'h9) v = mCtrl[b1[1:0]];
    else if (b1[7:4] == 4'hB) v = mData[b1[1:0]][b1[3:2]];
    else return 1'b0;
    return v[7-(n-16)];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < 4; c++) begin
        mCtrl[c] = 0;
        for (int r = 0; r < 4; r++) mData[c][r] = 0;
      end
      q.delete(); armed = 0;
    end else if (csN) begin
      if (armed) applyFrame();
      q.delete(); armed = 1;
    end else if (bitStb && armed) q.push_back(sdi);
  end

  task automatic check(string req, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [31:0] eC; logic [127:0] eD; logic [11:0] eW;
      for (int c = 0; c < 4; c++) begin
        eC[c*8 +: 8] = mCtrl[c];
        for (int r = 0; r < 4; r++) eD[(c*4+r)*8 +: 8] = mData[c][r];
      end
      eW = {mCtrl[1][5:0], mCtrl[0][5:0]};
      check({curReq, " ctrlRegs"}, ctrlRegs, eC);
      check({curReq, " dataRegs"}, dataRegs, eD);
      check({curReq, " sdo"}, sdo, expSdo());
      check("R11 wiperPos", wiperPos, eW);
      check("R11 cmp", {cmpPower, cmpOutEn, cmpLatch},
            {mCtrl[3][0], mCtrl[2][0], mCtrl[3][1], mCtrl[2][1], mCtrl[3][2], mCtrl[2][2]});
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1; fails++; checks++;
      $display("FAIL R-all watchdog got=%0d exp=<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic bitOut(input logic b);
    @(negedge clk); lastSdo = sdo; sdi = b; bitStb = 1;
    @(negedge clk); bitStb = 0;
  endtask
  task automatic byteOut(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bitOut(v[i]);
  endtask
  task automatic byteIn(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin bitOut(1'b0); v[i] = lastSdo; end
  endtask
  task automatic csDown(); @(negedge clk); csN = 0; endtask
  task automatic csUp(); @(negedge clk); csN = 1; @(negedge clk); @(negedge clk); endtask
  task automatic frame3(logic [7:0] a, logic [7:0] b, logic [7:0] c);
    csDown(); byteOut(a); byteOut(b); byteOut(c); csUp();
  endtask
  task automatic frame2(logic [7:0] a, logic [7:0] b);
    csDown(); byteOut(a); byteOut(b); csUp();
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    curReq = "R1";
    check("R1 reset ctrl", ctrlRegs, 0);
    check("R1 reset data", dataRegs, 0);
    check("R1 reset sdo", sdo, 0);
    rstN = 1;
    @(negedge clk);
    curReq = "R2";
    byteOut(8'h52); byteOut(8'hA0); byteOut(8'h2A);
    csUp();
    check("R2 no frame before select high", ctrlRegs[7:0], 8'h00);

    curReq = "R5";
    frame3(8'h52, 8'hA0, 8'hFF);
    check("R5 ctrl ch0 masked", ctrlRegs[7:0], 8'h3F);
    check("R11 wiper ch0", wiperPos[5:0], 6'h3F);
    curReq = "R4";
    frame3(8'h52, 8'hA2, 8'h07);
    check("R11 cmp ch2 bits", {cmpPower[0], cmpOutEn[0], cmpLatch[0]}, 3'b111);
    frame3(8'h52, 8'hA3, 8'h3A);
    check("R4 ctrl ch3", ctrlRegs[31:24], 8'h3A);
    check("R11 cmp ch3 bits", {cmpPower[1], cmpOutEn[1], cmpLatch[1]}, 3'b010);

    curReq = "R6";
    frame3(8'h52, 8'hC9, 8'hA5);
    check("R6 data ch1 rg2", dataRegs[55:48], 8'hA5);

    curReq = "R7";
    check("R7 sdo idle", sdo, 0);
    csDown(); byteOut(8'h52); byteOut(8'hB9); byteIn(rd); csUp();
    check("R7 read data ch1 rg2", rd, 8'hA5);
    csDown(); byteOut(8'h52); byteOut(8'h90); byteIn(rd); csUp();
    check("R7 read ctrl ch0", rd, 8'h3F);

    curReq = "R8";
    frame2(8'h52, 8'hD9);
    check("R8 copy data to ctrl ch1", ctrlRegs[15:8], 8'h25);
    frame2(8'h52, 8'hEE);
    check("R8 copy ctrl ch2 to data rg3", dataRegs[95:88], 8'h07);

    curReq = "R3";
    frame3(8'h62, 8'hA1, 8'h11);
    check("R3 wrong type", ctrlRegs[15:8], 8'h25);
    frame3(8'h51, 8'hA1, 8'h11);
    check("R3 wrong address", ctrlRegs[15:8], 8'h25);
    frame3(8'h56, 8'hA1, 8'h11);
    check("R3 nonzero middle bits", ctrlRegs[15:8], 8'h25);

    curReq = "R9";
    frame3(8'h52, 8'h01, 8'h11);
    check("R9 opcode 0000", ctrlRegs[15:8], 8'h25);
    frame3(8'h52, 8'hF1, 8'h11);
    check("R9 opcode 1111", ctrlRegs[15:8], 8'h25);

    curReq = "R10";
    csDown(); byteOut(8'h52); byteOut(8'hA1);
    for (int i = 0; i < 5; i++) bitOut(1'b1);
    csUp();
    check("R10 partial byte", ctrlRegs[15:8], 8'h25);
    csDown(); byteOut(8'h52); byteOut(8'hA1); byteOut(8'h11); bitOut(1'b0); csUp();
    check("R10 extra bit", ctrlRegs[15:8], 8'h25);
    csDown(); byteOut(8'h52); bitOut(1'b1); bitOut(1'b0); csUp();
    frame3(8'h52, 8'hA1, 8'h11);
    check("R10 fresh frame after abort", ctrlRegs[15:8], 8'h11);

    repeat (4) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule